// File: doc/BRIEF.md
# Indexed Prefix Instruction Decoder

This block decodes the index-register prefix bytes of an 8-bit CPU with IX and IY index registers, together with the four-byte indexed bit and shift group that follows those prefixes. It takes one fetched byte on each cycle where `byteValid` is high. It tracks where it is inside a prefixed sequence and produces a registered instruction record. The record carries a one-cycle valid pulse, an operation class, the index register select, the signed displacement, a bit number, a shift kind and an optional destination register.

Some prefix sequences cannot be finished here. A prefix followed by a second prefix byte is one case. A prefix followed by an ordinary opcode is another. In both cases the block emits a no-op and raises a rollback strobe, which tells the fetch unit to step the program counter back by one and present the same byte again. In the ordinary-opcode case the block also holds a pending-prefix indication. The neighbouring unprefixed decoder uses that indication when the refetched byte comes back.

Top module: `ixPrefixDecoder`

## Requirements
- R1: After synchronous reset, `outValid`, `rollback` and `pendPrefix` are all zero.
- R2: A prefix byte (0xDD selects IX, 0xFD selects IY) followed by 0xDD, 0xED or 0xFD produces a no-op record. In that record `outClass`=0, `outIndexSel` is the first prefix's register (0=IX, 1=IY) and every other field is zero. `rollback` is high with it, and `pendPrefix` stays 00. The refetched byte is then decoded afresh.
- R3: A prefix followed by any byte other than 0xCB, 0xDD, 0xED or 0xFD produces the same no-op with `rollback`. It also sets `pendPrefix` to 01 for IX or 10 for IY. `pendPrefix` returns to 00 when the next byte is accepted.
- R4: A prefix, then 0xCB, then displacement d, then opcode yields no record for the first three bytes and one record after the opcode. In that record `outIndexSel` gives the prefix and `outDisp` equals d.
- R5: Opcode field split: x = bits 7:6, y = bits 5:3, z = bits 2:0. When x=0 the class is shift (1), and `outShift`=y with this order: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL. `outBit` is 0.
- R6: When x=1 the class is bit test (2), `outBit`=y, `outShift`=0 and there is no destination, whatever z is.
- R7: When x=2 the class is reset-bit (3). When x=3 the class is set-bit (4). In both cases `outBit`=y and `outShift`=0.
- R8: For classes shift, reset-bit and set-bit, `outHasDest`=1 and `outDestReg`=z when z≠6. When z=6, both fields are 0. Register codes are 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A.
- R9: `outValid` and `rollback` rise in the cycle after the accepting edge and last one cycle. Cycles with `byteValid` low change nothing.
- R10: A byte accepted while no prefix is in progress, other than 0xDD or 0xFD, produces no record and no rollback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | Byte on `byteIn` is accepted this cycle |
| byteIn | input | 8 | Fetched instruction byte |
| outValid | output | 1 | One-cycle pulse, record fields valid |
| outClass | output | 3 | 0 no-op, 1 shift, 2 bit test, 3 reset-bit, 4 set-bit |
| outIndexSel | output | 1 | 0 = IX, 1 = IY |
| outDisp | output | 8 | Two's complement displacement |
| outBit | output | 3 | Bit number for bit classes |
| outShift | output | 3 | Shift/rotate kind |
| outHasDest | output | 1 | Result also copied to a register |
| outDestReg | output | 3 | Destination register code |
| rollback | output | 1 | Pulse: step the program counter back by one |
| pendPrefix | output | 2 | Latched prefix for the next decode: 00 none, 01 IX, 10 IY |

## Verification
Every record and every rollback pulse is registered. Each one is due in the cycle that follows the edge accepting the byte that completes it. `pendPrefix` changes at that same edge and clears at the edge accepting the following byte. The bench drives a byte on a falling edge, lets one rising edge pass, and samples everything on the next falling edge, so each check looks at exactly the cycle its result is due. Runs with idle cycles between the bytes confirm that nothing is emitted early and that nothing moves while `byteValid` is low.

// File: rtl/ixdec_pkg.sv
package ixdec_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 3;
  localparam logic [BYTE_W-1:0] PFX_IX  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IY  = 8'hFD;
  localparam logic [BYTE_W-1:0] PFX_EXT = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_BIT = 8'hCB;
  localparam logic [FIELD_W-1:0] MEM_CODE = 3'd6;

  typedef enum logic [FIELD_W-1:0] {
    OP_NOP = 3'd0, OP_SHIFT = 3'd1, OP_BIT = 3'd2, OP_RES = 3'd3, OP_SET = 3'd4
  } opClass_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PREFIX, ST_DISP, ST_OPC} phase_t;

  typedef struct packed {
    logic emitNop;
    logic doRollback;
    logic latchPrefix;
    logic clearLatch;
    logic capturePrefix;
    logic captureDisp;
    logic decodeOp;
  } strobes_t;
endpackage

// File: rtl/ixdecCtrl.sv
module ixdecCtrl
  import ixdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output strobes_t          strobes
);
  phase_t phase, phaseNext;
  logic isIndexPfx, isAnyPfx;

  assign isIndexPfx = (byteIn == PFX_IX) || (byteIn == PFX_IY);
  assign isAnyPfx   = isIndexPfx || (byteIn == PFX_EXT);

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    if (byteValid) begin
      unique case (phase)
        ST_IDLE: begin
          strobes.clearLatch = 1'b1;
          if (isIndexPfx) begin
            strobes.capturePrefix = 1'b1;
            phaseNext = ST_PREFIX;
          end
        end
        ST_PREFIX: begin
          if (byteIn == PFX_BIT) begin
            phaseNext = ST_DISP;
          end else begin
            strobes.emitNop     = 1'b1;
            strobes.doRollback  = 1'b1;
            strobes.latchPrefix = !isAnyPfx;
            phaseNext = ST_IDLE;
          end
        end
        ST_DISP: begin
          strobes.captureDisp = 1'b1;
          phaseNext = ST_OPC;
        end
        ST_OPC: begin
          strobes.decodeOp = 1'b1;
          phaseNext = ST_IDLE;
        end
        default: phaseNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= ST_IDLE;
    else     phase <= phaseNext;
  end
endmodule

// File: rtl/ixdecData.sv
module ixdecData
  import ixdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  byteIn,
  input  strobes_t           strobes,
  output logic               outValid,
  output logic [FIELD_W-1:0] outClass,
  output logic               outIndexSel,
  output logic [BYTE_W-1:0]  outDisp,
  output logic [FIELD_W-1:0] outBit,
  output logic [FIELD_W-1:0] outShift,
  output logic               outHasDest,
  output logic [FIELD_W-1:0] outDestReg,
  output logic               rollback,
  output logic [1:0]         pendPrefix
);
  logic              idxSel;
  logic [BYTE_W-1:0] dispReg;
  logic [1:0]          fx;
  logic [FIELD_W-1:0]  fy, fz;
  opClass_t            decClass;
  logic                decHasDest;

  assign fx = byteIn[7:6];
  assign fy = byteIn[5:3];
  assign fz = byteIn[2:0];

  always_comb begin
    unique case (fx)
      2'd0:    decClass = OP_SHIFT;
      2'd1:    decClass = OP_BIT;
      2'd2:    decClass = OP_RES;
      default: decClass = OP_SET;
    endcase
    decHasDest = (fx != 2'd1) && (fz != MEM_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      rollback    <= 1'b0;
      pendPrefix  <= 2'b00;
      idxSel      <= 1'b0;
      dispReg     <= '0;
      outClass    <= OP_NOP;
      outIndexSel <= 1'b0;
      outDisp     <= '0;
      outBit      <= '0;
      outShift    <= '0;
      outHasDest  <= 1'b0;
      outDestReg  <= '0;
    end else begin
      outValid <= strobes.emitNop | strobes.decodeOp;
      rollback <= strobes.doRollback;
      if (strobes.capturePrefix) idxSel  <= (byteIn == PFX_IY);
      if (strobes.captureDisp)   dispReg <= byteIn;
      if (strobes.clearLatch)    pendPrefix <= 2'b00;
      if (strobes.latchPrefix)   pendPrefix <= idxSel ? 2'b10 : 2'b01;
      if (strobes.emitNop) begin
        outClass    <= OP_NOP;
        outIndexSel <= idxSel;
        outDisp     <= '0;
        outBit      <= '0;
        outShift    <= '0;
        outHasDest  <= 1'b0;
        outDestReg  <= '0;
      end
      if (strobes.decodeOp) begin
        outClass    <= decClass;
        outIndexSel <= idxSel;
        outDisp     <= dispReg;
        outBit      <= (fx != 2'd0) ? fy : '0;
        outShift    <= (fx == 2'd0) ? fy : '0;
        outHasDest  <= decHasDest;
        outDestReg  <= decHasDest ? fz : '0;
      end
    end
  end
endmodule

// File: rtl/ixPrefixDecoder.sv
module ixPrefixDecoder
  import ixdec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         byteValid,
  input  logic [7:0]   byteIn,
  output logic         outValid,
  output logic [2:0]   outClass,
  output logic         outIndexSel,
  output logic [7:0]   outDisp,
  output logic [2:0]   outBit,
  output logic [2:0]   outShift,
  output logic         outHasDest,
  output logic [2:0]   outDestReg,
  output logic         rollback,
  output logic [1:0]   pendPrefix
);
  strobes_t strobes;

  ixdecCtrl ctrl_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn), .strobes(strobes)
  );

  ixdecData data_i (
    .clk(clk), .rst(rst), .byteIn(byteIn), .strobes(strobes),
    .outValid(outValid), .outClass(outClass), .outIndexSel(outIndexSel),
    .outDisp(outDisp), .outBit(outBit), .outShift(outShift),
    .outHasDest(outHasDest), .outDestReg(outDestReg),
    .rollback(rollback), .pendPrefix(pendPrefix)
  );
endmodule

// File: rtl/ixdecChk.sv
module ixdecChk (
  input logic       clk,
  input logic       rst,
  input logic       byteValid,
  input logic       outValid,
  input logic [2:0] outClass,
  input logic       outHasDest,
  input logic [2:0] outDestReg,
  input logic       rollback,
  input logic [1:0] pendPrefix
);
  // R2
  rollback_is_nop_chk: assert property (@(posedge clk) disable iff (rst)
    rollback |-> (outValid && outClass == 3'd0));
  // R3
  nop_has_rollback_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass == 3'd0) |-> rollback);
  // R9
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);
  // R9
  no_output_without_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !byteValid |=> (!outValid && !rollback));
  // R8
  dest_not_memory_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outHasDest) |-> (outDestReg != 3'd6));
  // R6
  bit_no_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass == 3'd2) |-> !outHasDest);
  // R3
  pend_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pendPrefix));
  // R5
  class_range_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outClass <= 3'd4));
endmodule

bind ixPrefixDecoder ixdecChk chk_i (
  .clk(clk), .rst(rst), .byteValid(byteValid), .outValid(outValid),
  .outClass(outClass), .outHasDest(outHasDest), .outDestReg(outDestReg),
  .rollback(rollback), .pendPrefix(pendPrefix)
);

// File: tb/ixPrefixDecoder_tb.sv
`timescale 1ns/1ps
module ixPrefixDecoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic outValid, outIndexSel, outHasDest, rollback;
  logic [2:0] outClass, outBit, outShift, outDestReg;
  logic [7:0] outDisp;
  logic [1:0] pendPrefix;

  int nVec = 0;
  int nBad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ixPrefixDecoder dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn),
    .outValid(outValid), .outClass(outClass), .outIndexSel(outIndexSel),
    .outDisp(outDisp), .outBit(outBit), .outShift(outShift),
    .outHasDest(outHasDest), .outDestReg(outDestReg),
    .rollback(rollback), .pendPrefix(pendPrefix)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nVec = nVec + 1;
    if (!ok) begin
      nBad = nBad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteIn = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
  endtask

  function automatic logic [22:0] recNow();
    return {outValid, outClass, outIndexSel, outDisp, outBit, outShift, outHasDest, outDestReg};
  endfunction

  function automatic logic [22:0] expOp(input logic iy, input logic [7:0] d, input logic [7:0] op);
    logic [1:0] x; logic [2:0] y, z, cls, bitN, shf, dst; logic hd;
    x = op[7:6]; y = op[5:3]; z = op[2:0];
    cls  = 3'(x) + 3'd1;
    bitN = (x == 0) ? 3'd0 : y;
    shf  = (x == 0) ? y : 3'd0;
    hd   = (x != 1) && (z != 3'd6);
    dst  = hd ? z : 3'd0;
    return {1'b1, cls, iy, d, bitN, shf, hd, dst};
  endfunction

  function automatic logic [22:0] expNop(input logic iy);
    return {1'b1, 3'd0, iy, 8'd0, 3'd0, 3'd0, 1'b0, 3'd0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(outValid == 0 && rollback == 0 && pendPrefix == 0, "R1 reset",
          {outValid, rollback, pendPrefix}, 0);

    // R4 R5 R6 R7 R8: full opcode sweep behind both prefixes
    for (int p = 0; p < 2; p++) begin
      for (int op = 0; op < 256; op++) begin
        logic [7:0] d;
        logic [7:0] pb;
        logic quiet;
        d = 8'(op) ^ 8'h5A ^ 8'(p * 8'h81);
        pb = (p == 0) ? 8'hDD : 8'hFD;
        quiet = 1'b1;
        sendByte(pb);   quiet &= !outValid && !rollback;
        sendByte(8'hCB); quiet &= !outValid && !rollback;
        sendByte(d);    quiet &= !outValid && !rollback;
        check(quiet, "R4 no early record", 0, 0);
        sendByte(8'(op));
        check(recNow() == expOp(p[0], d, 8'(op)) && !rollback,
              "R4/R5/R6/R7/R8 indexed bit-op record", recNow(), expOp(p[0], d, 8'(op)));
        idleCycle();
        // R9 pulse lasts one cycle
        check(!outValid, "R9 single-cycle valid", outValid, 0);
      end
    end

    // R2 R3: every second byte after a prefix except 0xCB
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] pb;
        logic isPfx;
        if (b == 8'hCB) continue;
        pb = (p == 0) ? 8'hDD : 8'hFD;
        isPfx = (b == 8'hDD) || (b == 8'hED) || (b == 8'hFD);
        sendByte(pb);
        sendByte(8'(b));
        if (isPfx) begin
          check(recNow() == expNop(p[0]) && rollback && pendPrefix == 2'b00,
                "R2 prefix-prefix nop", {recNow(), rollback, pendPrefix},
                {expNop(p[0]), 1'b1, 2'b00});
          // R2 refetched byte decoded afresh
          sendByte(8'(b));
          check(!outValid && !rollback, "R2 refetch", {outValid, rollback}, 0);
          if (b != 8'hED) begin
            sendByte(8'hCB); sendByte(8'h10); sendByte(8'h46);
            check(recNow() == expOp(b == 8'hFD, 8'h10, 8'h46), "R2 new prefix owns sequence",
                  recNow(), expOp(b == 8'hFD, 8'h10, 8'h46));
          end
        end else begin
          check(recNow() == expNop(p[0]) && rollback && pendPrefix == (p == 0 ? 2'b01 : 2'b10),
                "R3 prefix then opcode", {recNow(), rollback, pendPrefix},
                {expNop(p[0]), 1'b1, (p == 0 ? 2'b01 : 2'b10)});
          idleCycle();
          check(pendPrefix == (p == 0 ? 2'b01 : 2'b10) && !rollback, "R3/R9 latch held while idle",
                pendPrefix, (p == 0 ? 2'b01 : 2'b10));
          sendByte(8'(b));
          check(pendPrefix == 2'b00 && !outValid && !rollback, "R3/R10 latch cleared by refetch",
                {pendPrefix, outValid, rollback}, 0);
        end
      end
    end

    // R10: unprefixed bytes produce nothing
    for (int b = 0; b < 256; b++) begin
      if (b == 8'hDD || b == 8'hFD) continue;
      sendByte(8'(b));
      check(!outValid && !rollback && pendPrefix == 0, "R10 idle byte ignored",
            {outValid, rollback, pendPrefix}, 0);
    end

    // R9: gaps between bytes change nothing
    sendByte(8'hFD); idleCycle(); idleCycle();
    check(!outValid && !rollback, "R9 gap after prefix", {outValid, rollback}, 0);
    sendByte(8'hCB); idleCycle();
    sendByte(8'h80); idleCycle(); idleCycle();
    check(!outValid, "R9 gap after displacement", outValid, 0);
    sendByte(8'hFF);
    check(recNow() == expOp(1'b1, 8'h80, 8'hFF), "R9/R7 gapped set-bit with dest A",
          recNow(), expOp(1'b1, 8'h80, 8'hFF));

    // R1: reset mid-sequence clears state
    sendByte(8'hDD); sendByte(8'h21);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(pendPrefix == 0 && !outValid && !rollback, "R1 reset clears latch",
          {pendPrefix, outValid, rollback}, 0);
    sendByte(8'hCB);
    check(!outValid && !rollback, "R1 no prefix after reset", {outValid, rollback}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule